// File: doc/BRIEF.md
# Frame-Tagged Receive Sample FIFO

This block is the receive-side sample store of a serial audio and data port. A deserializer pushes one sample per cycle into it. Each sample is up to 20 bits wide and comes with a marker that says whether it opens a new frame. A 32-bit internal bus pops samples out of it. The bus read word is built according to the port's operating mode. In the byte and halfword modes, one read can pull several samples, packed from the top of the word downward. In the slot mode, each read returns exactly one slot, left-justified. The frame-start marker is then reflected in bit 11, just below the sample.

The block reports its fill level and its empty and full conditions. It also keeps a sticky overrun flag for samples that arrive with no room left. Every read result carries an underflow indication when fewer samples were stored than were requested. A receiver enable gates new samples but never gates reads, so the bus can drain what is left after the receiver is turned off. A receiver reset input empties the store and clears the status. After that reset, the receiver must be turned off and on again before it accepts samples.

Top module: `rx_sample_fifo`

## Requirements
- R1: After power-on reset the store is empty: `level`=0, `empty`=1, `full`=0, `overrun`=0, `rd_valid`=0. A sample offered with `wr_valid` while accepting raises `level` by one after that clock edge. `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` equals DEPTH. Samples leave in the order they arrived.
- R2: When `mode` is 2'b00 or 2'b01 (byte modes), a read takes 1 sample for `rd_count`=0, 2 for `rd_count`=1 and 4 for `rd_count`=2 or 3. The bits [7:0] of the oldest sample go to `rd_data[31:24]`, the next to [23:16], then [15:8], then [7:0]. Unused bits are 0.
- R3: When `mode` is 2'b10 (halfword mode), a read takes 1 sample for `rd_count`=0 and 2 otherwise. The bits [15:0] of the oldest sample go to `rd_data[31:16]` and those of the next to [15:0]. Unused bits are 0.
- R4: When `mode` is 2'b11 (slot mode), every read takes exactly one sample, whatever `rd_count` is. An untagged sample returns its 20 bits on `rd_data[31:12]` with bit 11 at 0. A sample stored with `wr_frame_start`=1 returns its bits [15:0] on `rd_data[31:16]` with bit 11 at 1. All other bits are 0.
- R5: A read requested with `rd_req` in one cycle produces `rd_valid`=1, `rd_data` and `rd_underflow` after the next rising edge. `rd_valid` is 0 in cycles that follow no request.
- R6: A read asking for more samples than are stored returns only the stored ones, packed as above with the rest zero, and sets `rd_underflow`=1 with that result. A read from an empty store returns 0 and removes nothing.
- R7: A sample offered while `full` is high is discarded, so `level` is unchanged, and `overrun` goes to 1. `overrun` stays 1 until a receiver reset.
- R8: While `rx_enable` is 0, offered samples are ignored, but reads still return and remove stored samples.
- R9: A cycle with `rx_reset`=1 empties the store, clears `overrun`, `rd_valid` and `rd_underflow`, and takes priority over a read or write in the same cycle.
- R10: After a receiver reset, samples are ignored even with `rx_enable`=1, until `rx_enable` has been seen at 0 for at least one cycle and is then 1 again.
- R11: A read and a write in the same cycle both take effect. Whether the write is discarded depends on `full` before that edge, so a write to a full store together with a one-sample read leaves `level` at DEPTH-1 and sets `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_enable | input | 1 | Receiver enable; gates incoming samples only |
| rx_reset | input | 1 | Synchronous receiver reset |
| mode | input | 2 | 00/01 byte, 10 halfword, 11 slot |
| wr_valid | input | 1 | Deserializer offers a sample |
| wr_data | input | 20 | Sample, right-aligned |
| wr_frame_start | input | 1 | Sample opens a new frame |
| rd_req | input | 1 | Bus read request |
| rd_count | input | 2 | Requested sample count code |
| rd_data | output | 32 | Packed read word |
| rd_valid | output | 1 | Read result present |
| rd_underflow | output | 1 | Read asked for more samples than stored |
| level | output | $clog2(DEPTH)+1 | Number of stored samples |
| empty | output | 1 | Store is empty |
| full | output | 1 | Store holds DEPTH samples |
| overrun | output | 1 | Sticky: a sample was dropped while full |

## Verification
Status outputs (`level`, `empty`, `full`, `overrun`) change at the rising edge that samples a write, read or receiver reset. A read result appears at the first rising edge after the request, one register deep. The bench drives every input on a falling edge and checks all outputs on the next falling edge, so each check lands in the half cycle right after the edge that produced it. Its reference queue is updated at the same point, using the fill level from before that edge. This ordering is what R11 depends on.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int SAMPLE_W = 20;
  localparam int WORD_W   = 32;
  localparam int LANES    = 4;

  typedef enum logic [1:0] {
    MODE_SERIAL = 2'b00,
    MODE_BYTE   = 2'b01,
    MODE_HALF   = 2'b10,
    MODE_SLOT   = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic                tag;
    logic [SAMPLE_W-1:0] smp;
  } rx_entry_t;

  // Number of samples a read asks for, given the mode and the count code.
  function automatic logic [2:0] req_lanes(rx_mode_e m, logic [1:0] code);
    logic [2:0] n;
    case (m)
      MODE_SLOT: n = 3'd1;
      MODE_HALF: n = (code == 2'd0) ? 3'd1 : 3'd2;
      default:   n = (code == 2'd0) ? 3'd1 : ((code == 2'd1) ? 3'd2 : 3'd4);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        wr_go,
  input  rx_entry_t                   din,
  input  logic [2:0]                  pop,
  output rx_entry_t [LANES-1:0]       win,
  output logic [CW-1:0]               count,
  output logic                        full,
  output logic                        empty,
  output logic                        overrun
);

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wptr_q, wptr_n;
  logic [AW-1:0]   rptr_q, rptr_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            ovr_q, ovr_n;
  logic            push;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign push  = wr_go & ~full & ~clr;

  always_comb begin
    if (clr) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
      ovr_n  = 1'b0;
    end else begin
      wptr_n = wptr_q + AW'(push);
      rptr_n = rptr_q + AW'(pop);
      cnt_n  = cnt_q + CW'(push) - CW'(pop);
      ovr_n  = ovr_q | (wr_go & full);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
      ovr_q  <= ovr_n;
    end
  end

  // Storage array, write-enabled, no reset.
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wptr_q] <= din;
    end
  end

  // Read window: the LANES oldest entries starting at the read pointer.
  for (genvar g = 0; g < LANES; g++) begin : g_win
    assign win[g] = mem[rptr_q + AW'(g)];
  end

  assign count   = cnt_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/rxf_pack.sv
module rxf_pack
  import rxf_pkg::*;
(
  input  rx_mode_e              mode,
  input  logic [2:0]            take,
  input  rx_entry_t [LANES-1:0] win,
  output logic [WORD_W-1:0]     word
);

  logic unused_win_bits;
  assign unused_win_bits = ^{win[1].tag, win[2].tag, win[3].tag,
                             win[1].smp[19:16], win[2].smp[19:8], win[3].smp[19:8]};

  always_comb begin
    word = '0;
    case (mode)
      MODE_SLOT: begin
        if (take != 3'd0) begin
          if (win[0].tag) begin
            word[31:16] = win[0].smp[15:0];
            word[11]    = 1'b1;
          end else begin
            word[31:12] = win[0].smp;
          end
        end
      end
      MODE_HALF: begin
        for (int i = 0; i < 2; i++) begin
          if (3'(i) < take) begin
            word[31-16*i -: 16] = win[i].smp[15:0];
          end
        end
      end
      default: begin
        for (int i = 0; i < LANES; i++) begin
          if (3'(i) < take) begin
            word[31-8*i -: 8] = win[i].smp[7:0];
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/rx_sample_fifo.sv
module rx_sample_fifo
  import rxf_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic          rx_reset,
  input  logic [1:0]    mode,
  input  logic          wr_valid,
  input  logic [19:0]   wr_data,
  input  logic          wr_frame_start,
  input  logic          rd_req,
  input  logic [1:0]    rd_count,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic          rd_underflow,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          overrun
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  rx_mode_e              mode_e;
  rx_entry_t             din;
  rx_entry_t [LANES-1:0] win;
  logic [CW-1:0]         count;
  logic [2:0]            want, take, pop;
  logic                  short_rd;
  logic                  armed_q, armed_n;
  logic                  wr_go;
  logic [WORD_W-1:0]     packed_word;
  logic [WORD_W-1:0]     rdata_q, rdata_n;
  logic                  rvalid_q, rvalid_n;
  logic                  ruflow_q, ruflow_n;

  assign mode_e   = rx_mode_e'(mode);
  assign din      = '{tag: wr_frame_start, smp: wr_data};
  assign want     = req_lanes(mode_e, rd_count);
  assign short_rd = (CW'(want) > count);
  assign take     = short_rd ? count[2:0] : want;
  assign pop      = (rd_req & ~rx_reset) ? take : 3'd0;

  // Re-arm: cleared by a receiver reset, set once the enable is seen low.
  always_comb begin
    if (rx_reset)        armed_n = 1'b0;
    else if (!rx_enable) armed_n = 1'b1;
    else                 armed_n = armed_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed_q <= 1'b1;
    else             armed_q <= armed_n;
  end

  assign wr_go = wr_valid & rx_enable & armed_q & ~rx_reset;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (rx_reset),
    .wr_go   (wr_go),
    .din     (din),
    .pop     (pop),
    .win     (win),
    .count   (count),
    .full    (full),
    .empty   (empty),
    .overrun (overrun)
  );

  rxf_pack u_pack (
    .mode (mode_e),
    .take (take),
    .win  (win),
    .word (packed_word)
  );

  // Read result register.
  always_comb begin
    rdata_n  = rdata_q;
    rvalid_n = 1'b0;
    ruflow_n = 1'b0;
    if (rx_reset) begin
      rdata_n = '0;
    end else if (rd_req) begin
      rdata_n  = packed_word;
      rvalid_n = 1'b1;
      ruflow_n = short_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      ruflow_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_n;
      rvalid_q <= rvalid_n;
      ruflow_q <= ruflow_n;
    end
  end

  assign rd_data      = rdata_q;
  assign rd_valid     = rvalid_q;
  assign rd_underflow = ruflow_q;
  assign level        = count;

endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          rx_enable,
  input logic          rx_reset,
  input logic [1:0]    mode,
  input logic          rd_req,
  input logic [31:0]   rd_data,
  input logic          rd_valid,
  input logic          rd_underflow,
  input logic [CW-1:0] level,
  input logic          empty,
  input logic          full,
  input logic          overrun
);

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    level <= CW'(DEPTH));

  assert_slot_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_req && !rx_reset && mode == 2'b11) |=> (rd_data[10:0] == 11'd0));

  assert_valid_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_req && !rx_reset) |=> rd_valid);

  assert_idle_no_valid_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_req |=> !rd_valid);

  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (full && !rd_req && !rx_reset) |=> full);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (overrun && !rx_reset) |=> overrun);

  assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rx_enable && !rd_req && !rx_reset) |=> (level == $past(level)));

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_reset |=> (empty && !overrun && !rd_valid && !rd_underflow));

endmodule

bind rx_sample_fifo rxf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .rx_enable    (rx_enable),
  .rx_reset     (rx_reset),
  .mode         (mode),
  .rd_req       (rd_req),
  .rd_data      (rd_data),
  .rd_valid     (rd_valid),
  .rd_underflow (rd_underflow),
  .level        (level),
  .empty        (empty),
  .full         (full),
  .overrun      (overrun)
);

// File: tb/rx_sample_fifo_tb.sv
`timescale 1ns/1ps
module rx_sample_fifo_tb;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_enable;
  logic          rx_reset;
  logic [1:0]    mode;
  logic          wr_valid;
  logic [19:0]   wr_data;
  logic          wr_frame_start;
  logic          rd_req;
  logic [1:0]    rd_count;
  logic [31:0]   rd_data;
  logic          rd_valid;
  logic          rd_underflow;
  logic [CW-1:0] level;
  logic          empty;
  logic          full;
  logic          overrun;

  always #10 clk = ~clk;  // 50 MHz

  rx_sample_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk (clk), .rst_n (rst_n), .rx_enable (rx_enable), .rx_reset (rx_reset),
    .mode (mode), .wr_valid (wr_valid), .wr_data (wr_data),
    .wr_frame_start (wr_frame_start), .rd_req (rd_req), .rd_count (rd_count),
    .rd_data (rd_data), .rd_valid (rd_valid), .rd_underflow (rd_underflow),
    .level (level), .empty (empty), .full (full), .overrun (overrun)
  );

  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  logic [20:0] q[$];
  bit          arm_e  = 1;
  bit          ovr_e  = 0;

  task automatic ck(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lanes(int m, int c);
    if (m == 3) return 1;
    if (m == 2) return (c == 0) ? 1 : 2;
    return (c == 0) ? 1 : ((c == 1) ? 2 : 4);
  endfunction

  task automatic status(string tag);
    ck(tag, 32'(level), 32'(q.size()));
    ck(tag, 32'(empty), 32'(q.size() == 0));
    ck(tag, 32'(full), 32'(q.size() == DEPTH));
    ck(tag, 32'(overrun), 32'(ovr_e));
  endtask

  // One cycle with optional write and read; checks at the following falling edge.
  task automatic cyc(bit wv, logic [19:0] wd, bit wt, bit rv, int rc, string tag);
    int          pre, n, tk;
    bit          uf;
    logic [31:0] ew;
    logic [20:0] e;
    pre = q.size();
    n   = lanes(int'(mode), rc);
    tk  = (n < pre) ? n : pre;
    uf  = (n > pre);
    ew  = 32'h0;
    for (int i = 0; i < tk; i++) begin
      e = q[i];
      if (mode == 2'b11) begin
        if (e[20]) ew = ({16'h0, e[15:0]} << 16) | 32'h800;
        else       ew = {12'h0, e[19:0]} << 12;
      end else if (mode == 2'b10) begin
        ew = ew | ({16'h0, e[15:0]} << (16 - 16 * i));
      end else begin
        ew = ew | ({24'h0, e[7:0]} << (24 - 8 * i));
      end
    end
    @(negedge clk);
    wr_valid = wv; wr_data = wd; wr_frame_start = wt;
    rd_req = rv; rd_count = 2'(rc);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; rd_req = 0;
    if (rv) begin
      for (int i = 0; i < tk; i++) void'(q.pop_front());
      ck(tag, 32'(rd_valid), 32'h1);
      ck(tag, rd_data, ew);
      ck(tag, 32'(rd_underflow), 32'(uf));
    end
    if (wv && rx_enable && arm_e) begin
      if (pre == DEPTH) ovr_e = 1;
      else              q.push_back({wt, wd});
    end
    status(tag);
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_rxreset();
    @(negedge clk);
    rx_reset = 1;
    @(posedge clk);
    @(negedge clk);
    rx_reset = 0;
    q.delete(); ovr_e = 0; arm_e = 0;
    status("R9");
    ck("R9 valid", 32'(rd_valid), 32'h0);
    ck("R9 uflow", 32'(rd_underflow), 32'h0);
  endtask

  task automatic rearm();
    @(negedge clk);
    rx_enable = 0;
    @(negedge clk);
    rx_enable = 1;
    arm_e = 1;
  endtask

  function automatic logic [19:0] pat(int a, int b, int c);
    return 20'((32'h9A5C3 ^ (a * 32'h1111) ^ (b << 8) ^ (c * 32'h35)) & 32'hFFFFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_enable = 1; rx_reset = 0; mode = 2'b01;
    wr_valid = 0; wr_data = '0; wr_frame_start = 0; rd_req = 0; rd_count = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    // R1: power-on state
    status("R1");
    ck("R1 valid", 32'(rd_valid), 32'h0);

    // R1, R5: a few writes and reads in order
    mode = 2'b01;
    for (int i = 0; i < 3; i++) cyc(1, pat(i, 1, 1), 0, 0, 0, "R1");
    cyc(0, '0, 0, 1, 0, "R5");
    idle(1);
    ck("R5 idle", 32'(rd_valid), 32'h0);

    // R10: after a receiver reset, writes wait for the enable to toggle
    do_rxreset();
    cyc(1, 20'h12345, 0, 0, 0, "R10 blocked");
    rearm();
    cyc(1, 20'h12345, 0, 0, 0, "R10 rearmed");

    // R2, R6: byte modes, all count codes over several fill levels
    for (int m = 0; m < 2; m++) begin
      mode = 2'(m);
      for (int c = 0; c < 4; c++) begin
        for (int f = 0; f < 6; f++) begin
          do_rxreset(); rearm();
          for (int i = 0; i < f; i++) cyc(1, pat(i, f, c + m), 0, 0, 0, "R2");
          cyc(0, '0, 0, 1, c, (f < lanes(m, c)) ? "R6" : "R2");
        end
      end
    end

    // R3, R6: halfword mode
    mode = 2'b10;
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 4; f++) begin
        do_rxreset(); rearm();
        for (int i = 0; i < f; i++) cyc(1, pat(i, f, c + 7), 0, 0, 0, "R3");
        cyc(0, '0, 0, 1, c, (f < lanes(2, c)) ? "R6" : "R3");
      end
    end

    // R4: slot mode, tagged and untagged entries, every count code
    mode = 2'b11;
    do_rxreset(); rearm();
    for (int i = 0; i < 9; i++) cyc(1, pat(i, 3, 11), (i % 3) == 0, 0, 0, "R4");
    for (int i = 0; i < 10; i++) cyc(0, '0, 0, 1, i % 4, (i < 9) ? "R4" : "R6");

    // R7: fill to full, then overflow and drain in order
    mode = 2'b01;
    do_rxreset(); rearm();
    for (int i = 0; i < DEPTH; i++) cyc(1, pat(i, 9, 2), 0, 0, 0, "R7");
    cyc(1, 20'hFFFFF, 0, 0, 0, "R7 drop");
    idle(2);
    status("R7 sticky");
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, 1, 3, "R7 drain");

    // R11: simultaneous read and write on a full store, then mid-level
    do_rxreset(); rearm();
    for (int i = 0; i < DEPTH; i++) cyc(1, pat(i, 5, 4), 0, 0, 0, "R11");
    cyc(1, 20'hABCDE, 0, 1, 0, "R11 full");
    cyc(1, 20'h0F0F0, 0, 1, 1, "R11 mid");
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, 1, 2, "R11 drain");

    // R8: disabled receiver ignores writes, reads still drain
    do_rxreset(); rearm();
    for (int i = 0; i < 5; i++) cyc(1, pat(i, 2, 6), 0, 0, 0, "R8");
    @(negedge clk); rx_enable = 0;
    for (int i = 0; i < 3; i++) cyc(1, 20'h55555, 0, 0, 0, "R8 ignored");
    for (int i = 0; i < 6; i++) cyc(0, '0, 0, 1, 0, "R8 read");
    @(negedge clk); rx_enable = 1; arm_e = 1;

    // R9: reset beats a same-cycle read and write
    for (int i = 0; i < 3; i++) cyc(1, pat(i, 4, 8), 0, 0, 0, "R9");
    @(negedge clk);
    rx_reset = 1; rd_req = 1; wr_valid = 1; wr_data = 20'h77777;
    @(posedge clk);
    @(negedge clk);
    rx_reset = 0; rd_req = 0; wr_valid = 0;
    q.delete(); ovr_e = 0; arm_e = 0;
    status("R9 priority");
    ck("R9 priority valid", 32'(rd_valid), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule